// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This peripheral keeps time as a free-running 32-bit count of seconds. A single-cycle tick pulse, one per second and already synchronous to the bus clock, advances the count whenever counting is enabled. Software reaches the block through a simple two-phase (setup, then access) register bus. Over that bus it can preset the count, read the count back, and program a match value for the alarm.

When the count takes on a value equal to the match value, a sticky raw alarm flag is raised. The count takes on a new value either by ticking or by being loaded. The flag is visible in a raw status register whatever the mask says. A one-bit mask gates the flag into a masked status register and onto the interrupt line. Software removes the flag by writing a one to the clear register.

The register words sit at fixed byte offsets, and bit 0 of each interrupt-related word is the alarm:

| Offset | Use |
|---|---|
| 0x00 | current count (read) |
| 0x04 | match value |
| 0x08 | load (write only) |
| 0x0C | control |
| 0x10 | mask |
| 0x14 | raw status |
| 0x18 | masked status |
| 0x1C | clear (write only) |

Top module: `sec_rtc`

## Requirements
- R1: After reset, every readable register (count, match, control, mask, raw status, masked status) reads zero, and `irq` is low.
- R2: A write to offset 0x08 sets the count to the written 32-bit value, and a read of offset 0x00 returns that value until the count changes.
- R3: While control bit 0 is 1, each `tick` pulse increments the count by one, wrapping from 0xFFFFFFFF to 0. While control bit 0 is 0, a tick leaves the count unchanged.
- R4: A load write and an enabled tick in the same cycle leave the count at the loaded value.
- R5: Raw status bit 0 becomes 1 in the cycle where the count, after a load or an increment, equals the match value (offset 0x04). The bit then stays 1 until it is cleared. Writing a match value equal to the current count does not set it.
- R6: Writing 1 in bit 0 of offset 0x1C clears raw status bit 0. Writing 0 there leaves it unchanged.
- R7: If a clear write and a new match happen in the same cycle, raw status bit 0 ends up 1.
- R8: Masked status bit 0 (offset 0x18) equals raw bit 0 AND mask bit 0 (offset 0x10), and `irq` equals that masked bit. The raw bit reads 1 even while the mask is 0.
- R9: In control, mask, raw and masked status, only bit 0 is stored and bits 31:1 read 0. Offsets 0x08 and 0x1C read 0, as does any offset above 0x1C.
- R10: A register write takes effect only in the access phase (`sel` and `enable` both 1). A setup-phase cycle with `write` high changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Block selected for a transfer |
| enable | input | 1 | Access phase of the transfer |
| write | input | 1 | 1 for a write, 0 for a read |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid during the access phase |
| tick | input | 1 | One-cycle pulse once per second |
| irq | output | 1 | Alarm interrupt (masked alarm) |

## Verification
The hardest case to reach from the ports is a clear write that lands in the same cycle as the tick that makes the count reach the match value. To get there, the stimulus loads the count to one below the match value and enables counting. It then raises `tick` only in the access cycle of the clear write. The wrap from 0xFFFFFFFF to a zero match value also needs a deliberate load. The random phase writes match values a few counts ahead of the modelled count, so that matches occur often.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned REG_WORDS = 8;
  localparam int unsigned IDX_W     = $clog2(REG_WORDS);

  typedef enum logic [IDX_W-1:0] {
    RI_COUNT  = 3'd0,
    RI_MATCH  = 3'd1,
    RI_LOAD   = 3'd2,
    RI_CTRL   = 3'd3,
    RI_MASK   = 3'd4,
    RI_RAW    = 3'd5,
    RI_MSKD   = 3'd6,
    RI_CLEAR  = 3'd7
  } reg_idx_e;

  localparam int unsigned OFF_COUNT = 32'h00;
  localparam int unsigned OFF_MATCH = 32'h04;
  localparam int unsigned OFF_LOAD  = 32'h08;
  localparam int unsigned OFF_CTRL  = 32'h0C;
  localparam int unsigned OFF_MASK  = 32'h10;
  localparam int unsigned OFF_RAW   = 32'h14;
  localparam int unsigned OFF_MSKD  = 32'h18;
  localparam int unsigned OFF_CLEAR = 32'h1C;
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_bus_regs.sv
module rtc_bus_regs
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              enable,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] cnt_val,
  input  logic              raw_flag,
  output logic [DATA_W-1:0] match_val,
  output logic              cnt_en,
  output logic              mask_bit,
  output logic              load_we,
  output logic              clear_we
);
  localparam int unsigned LOW_W = IDX_W + 2;

  logic     hit;
  reg_idx_e idx;
  logic     wr_acc;
  logic     match_we, ctrl_we, mask_we;

  logic [DATA_W-1:0] match_q, match_d;
  logic              en_q, en_d;
  logic              mask_q, mask_d;

  // offset decode: word aligned, nothing above the register window
  always_comb begin
    hit = (addr[1:0] == 2'b00);
    if (ADDR_W > LOW_W) begin
      hit = hit && (addr[ADDR_W-1:LOW_W] == '0);
    end
    idx    = reg_idx_e'(addr[LOW_W-1:2]);
    wr_acc = sel && enable && write && hit;
  end

  always_comb begin
    match_we = wr_acc && (idx == RI_MATCH);
    ctrl_we  = wr_acc && (idx == RI_CTRL);
    mask_we  = wr_acc && (idx == RI_MASK);
    load_we  = wr_acc && (idx == RI_LOAD);
    clear_we = wr_acc && (idx == RI_CLEAR);
  end

  always_comb begin
    match_d = match_q;
    en_d    = en_q;
    mask_d  = mask_q;
    if (match_we) match_d = wdata;
    if (ctrl_we)  en_d    = wdata[0];
    if (mask_we)  mask_d  = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      en_q    <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      if (match_we) match_q <= match_d;
      if (ctrl_we)  en_q    <= en_d;
      if (mask_we)  mask_q  <= mask_d;
    end
  end

  // read mux, single-bit registers zero extended
  always_comb begin
    rdata = '0;
    if (hit) begin
      unique case (idx)
        RI_COUNT: rdata = cnt_val;
        RI_MATCH: rdata = match_q;
        RI_CTRL:  rdata = {{(DATA_W-1){1'b0}}, en_q};
        RI_MASK:  rdata = {{(DATA_W-1){1'b0}}, mask_q};
        RI_RAW:   rdata = {{(DATA_W-1){1'b0}}, raw_flag};
        RI_MSKD:  rdata = {{(DATA_W-1){1'b0}}, raw_flag & mask_q};
        default:  rdata = '0;
      endcase
    end
  end

  assign match_val = match_q;
  assign cnt_en    = en_q;
  assign mask_bit  = mask_q;
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              tick,
  input  logic              load_we,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] cnt_q,
  output logic [DATA_W-1:0] cnt_d,
  output logic              cnt_upd
);
  always_comb begin
    cnt_d   = cnt_q;
    cnt_upd = 1'b0;
    if (load_we) begin
      cnt_d   = load_val;
      cnt_upd = 1'b1;
    end else if (cnt_en && tick) begin
      cnt_d   = cnt_q + 1'b1;
      cnt_upd = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_upd) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_upd,
  input  logic [DATA_W-1:0] cnt_next,
  input  logic [DATA_W-1:0] match_val,
  input  logic              clear_we,
  input  logic              clear_bit,
  input  logic              mask_bit,
  output logic              raw_q,
  output logic              irq
);
  logic set_evt, clr_evt, raw_d, raw_we;

  always_comb begin
    set_evt = cnt_upd && (cnt_next == match_val);
    clr_evt = clear_we && clear_bit;
    raw_we  = set_evt || clr_evt;
    raw_d   = raw_q;
    if (clr_evt) raw_d = 1'b0;
    if (set_evt) raw_d = 1'b1;   // set beats clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
    end else if (raw_we) begin
      raw_q <= raw_d;
    end
  end

  assign irq = raw_q & mask_bit;
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              enable,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              tick,
  output logic              irq
);
  logic              rst_n_s;
  logic [DATA_W-1:0] cnt_q, cnt_d, match_q;
  logic              cnt_upd, en_q, mask_q, raw_q, load_we, clear_we;

  rtc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  rtc_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .sel(sel), .enable(enable), .write(write),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cnt_val(cnt_q),
    .raw_flag(raw_q), .match_val(match_q), .cnt_en(en_q), .mask_bit(mask_q),
    .load_we(load_we), .clear_we(clear_we)
  );

  rtc_sec_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .cnt_en(en_q), .tick(tick),
    .load_we(load_we), .load_val(wdata), .cnt_q(cnt_q), .cnt_d(cnt_d),
    .cnt_upd(cnt_upd)
  );

  rtc_alarm_flag #(.DATA_W(DATA_W)) u_alarm (
    .clk(clk), .rst_n(rst_n_s), .cnt_upd(cnt_upd), .cnt_next(cnt_d),
    .match_val(match_q), .clear_we(clear_we), .clear_bit(wdata[0]),
    .mask_bit(mask_q), .raw_q(raw_q), .irq(irq)
  );
endmodule

// File: rtl/sec_rtc_checker.sv
module sec_rtc_checker
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              sel,
  input logic              enable,
  input logic              write,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              tick,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] match_q,
  input logic              en_q,
  input logic              mask_q,
  input logic              raw_q,
  input logic              irq
);
  logic wr_load, wr_clr1, wr_ctrl;
  assign wr_load = sel && enable && write && (addr == ADDR_W'(OFF_LOAD));
  assign wr_clr1 = sel && enable && write && (addr == ADDR_W'(OFF_CLEAR)) && wdata[0];
  assign wr_ctrl = sel && write && (addr == ADDR_W'(OFF_CTRL));

  AST_LOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_load |=> cnt_q == $past(wdata)); // R2
  AST_TICK_INC: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!wr_load && en_q && tick) |=> cnt_q == $past(cnt_q) + 1'b1); // R3
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!wr_load && !(en_q && tick)) |=> $stable(cnt_q)); // R3
  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (raw_q && !wr_clr1) |=> raw_q); // R5
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_clr1 && !wr_load && !tick) |=> !raw_q); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_clr1 && en_q && tick && (cnt_q + 1'b1 == match_q)) |=> raw_q); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq |-> (raw_q && mask_q)); // R8
  AST_SETUP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_ctrl && !enable) |=> $stable(en_q)); // R10
endmodule

bind sec_rtc sec_rtc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .sel(sel), .enable(enable), .write(write),
  .addr(addr), .wdata(wdata), .tick(tick), .cnt_q(cnt_q), .match_q(match_q),
  .en_q(en_q), .mask_q(mask_q), .raw_q(raw_q), .irq(irq)
);

// File: tb/tb_sec_rtc.sv
module tb_sec_rtc;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel, enable, write, tick;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [31:0] m_cnt, m_match;
  logic        m_en, m_mask, m_raw;

  sec_rtc #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .enable(enable), .write(write),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tick(tick), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors = errors + 1;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    case (a)
      12'h000: exp_read = m_cnt;
      12'h004: exp_read = m_match;
      12'h00C: exp_read = {31'b0, m_en};
      12'h010: exp_read = {31'b0, m_mask};
      12'h014: exp_read = {31'b0, m_raw};
      12'h018: exp_read = {31'b0, m_raw & m_mask};
      default: exp_read = 32'h0;
    endcase
  endfunction

  task automatic model_step(input logic wr, input logic [11:0] a,
                            input logic [31:0] wd, input logic tk);
    logic [31:0] nxt;
    logic upd, clr, st;
    nxt = m_cnt; upd = 1'b0;
    if (wr && a == 12'h008) begin nxt = wd; upd = 1'b1; end
    else if (m_en && tk) begin nxt = m_cnt + 1; upd = 1'b1; end
    clr = wr && a == 12'h01C && wd[0];
    st  = upd && (nxt == m_match);
    if (clr) m_raw = 1'b0;
    if (st)  m_raw = 1'b1;
    if (wr && a == 12'h004) m_match = wd;
    if (wr && a == 12'h00C) m_en = wd[0];
    if (wr && a == 12'h010) m_mask = wd[0];
    m_cnt = nxt;
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one bus transfer; tick may be raised in its access cycle
  task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] wd,
                      input logic tk, output logic [31:0] rd);
    @(negedge clk);
    sel = 1'b1; enable = 1'b0; write = wr; addr = a; wdata = wd; tick = 1'b0;
    @(negedge clk);
    enable = 1'b1; tick = tk;
    #1 rd = rdata;
    @(negedge clk);
    sel = 1'b0; enable = 1'b0; write = 1'b0; tick = 1'b0;
    model_step(wr, a, wd, tk);
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] wd, input logic tk);
    logic [31:0] d;
    xfer(1'b1, a, wd, tk, d);
  endtask

  task automatic rd_check(input string tag, input logic [11:0] a);
    logic [31:0] d;
    xfer(1'b0, a, 32'h0, 1'b0, d);
    check(tag, $sformatf("read %h", a), d, exp_read(a));
  endtask

  task automatic irq_check(input string tag);
    #1 check(tag, "irq", {31'b0, irq}, {31'b0, m_raw & m_mask});
  endtask

  task automatic idle_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    model_step(1'b0, 12'h0, 32'h0, 1'b1);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    m_cnt = 0; m_match = 0; m_en = 0; m_mask = 0; m_raw = 0;
    sel = 0; enable = 0; write = 0; tick = 0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 8; i++) rd_check("R1", 12'(i * 4));
    irq_check("R1");

    // R2 load and read back
    wr_reg(12'h008, 32'h1234_5678, 1'b0);
    rd_check("R2", 12'h000);

    // R3 disabled tick ignored, then counting and wrap
    idle_tick();
    rd_check("R3", 12'h000);
    wr_reg(12'h00C, 32'h1, 1'b0);
    idle_tick(); idle_tick(); idle_tick();
    rd_check("R3", 12'h000);
    wr_reg(12'h008, 32'hFFFF_FFFF, 1'b0);
    idle_tick();
    rd_check("R3", 12'h000);
    check("R5", "wrap to zero match sets raw", {31'b0, m_raw}, 32'h1);
    rd_check("R5", 12'h014);

    // R4 load beats tick
    wr_reg(12'h008, 32'h0000_0500, 1'b1);
    rd_check("R4", 12'h000);

    // R6 clear by writing 1, 0 has no effect
    wr_reg(12'h01C, 32'hFFFF_FFFE, 1'b0);
    rd_check("R6", 12'h014);
    wr_reg(12'h01C, 32'h1, 1'b0);
    rd_check("R6", 12'h014);

    // R5 match on increment, sticky; match write alone does not set
    wr_reg(12'h004, 32'd100, 1'b0);
    wr_reg(12'h008, 32'd99, 1'b0);
    rd_check("R5", 12'h014);
    idle_tick();
    rd_check("R5", 12'h014);
    idle_tick(); idle_tick();
    rd_check("R5", 12'h014);
    wr_reg(12'h01C, 32'h1, 1'b0);
    wr_reg(12'h004, m_cnt, 1'b0);
    rd_check("R5", 12'h014);

    // R8 raw visible while masked, irq follows mask
    wr_reg(12'h008, m_match, 1'b0);
    rd_check("R8", 12'h014);
    rd_check("R8", 12'h018);
    irq_check("R8");
    wr_reg(12'h010, 32'h1, 1'b0);
    rd_check("R8", 12'h018);
    irq_check("R8");

    // R7 clear and match in the same cycle
    wr_reg(12'h008, m_match - 1, 1'b0);
    wr_reg(12'h01C, 32'h1, 1'b1);
    rd_check("R7", 12'h014);
    irq_check("R7");

    // R9 unused bits and write-only or unmapped offsets
    wr_reg(12'h00C, 32'hFFFF_FFFF, 1'b0);
    wr_reg(12'h010, 32'hFFFF_FFFF, 1'b0);
    rd_check("R9", 12'h00C);
    rd_check("R9", 12'h010);
    rd_check("R9", 12'h008);
    rd_check("R9", 12'h01C);
    xfer(1'b0, 12'h020, 32'h0, 1'b0, d);
    check("R9", "unmapped 0x020", d, 32'h0);
    xfer(1'b0, 12'h404, 32'h0, 1'b0, d);
    check("R9", "unmapped 0x404", d, 32'h0);

    // R10 setup-only write has no effect
    @(negedge clk);
    sel = 1'b1; enable = 1'b0; write = 1'b1; addr = 12'h00C; wdata = 32'h0;
    @(negedge clk);
    sel = 1'b0; write = 1'b0;
    rd_check("R10", 12'h00C);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom % 8;
      case (op)
        0: wr_reg(12'h008, ($urandom % 2) ? $urandom : m_match - ($urandom % 3), $urandom % 2);
        1: wr_reg(12'h004, m_cnt + ($urandom % 4), $urandom % 2);
        2: wr_reg(12'h00C, $urandom, $urandom % 2);
        3: wr_reg(12'h010, $urandom, $urandom % 2);
        4: wr_reg(12'h01C, $urandom, $urandom % 2);
        5: idle_tick();
        default: begin
          logic [11:0] a;
          a = 12'(($urandom % 8) * 4);
          case (a)
            12'h000: rd_check("R3", a);
            12'h014: rd_check("R5", a);
            12'h018: rd_check("R8", a);
            default: rd_check("R9", a);
          endcase
          irq_check("R8");
        end
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule